// File: doc/BRIEF.md
# Directory Line Tagging Engine

This block keeps a small monitoring tag beside each entry of a directory header store. Each tag pairs a ten-bit data-bin identifier with a warm flag. Software labels a region of memory by sending one command that names a starting physical address, a length counted in 128-byte lines, and the bin to apply. The engine then walks those entries one per clock, writing the bin into each and clearing its warm flag. Counting statistics per data structure and spotting first-touch misses then cost no extra lookups.

On every data reply the block looks up the line's tag and returns the bin and a cold indication one cycle later. The cold indication is set when the warm flag was clear. It then marks the line warm, so that only the first reply after labelling or reset counts as cold. While a walk is in progress, new commands are refused with a retry signal. A reply that hits the entry the walk is about to write wins that cycle, and the walk waits one clock.

Top module: `line_tag_engine`

## Requirements
- R1: After reset every tag holds bin 0 with the warm flag clear, `busy`, `cmd_retry` and `rep_out_valid` are 0, and the first reply to any line reports bin 0 with `rep_cold` = 1.
- R2: A reply presented with `rep_valid` = 1 at a clock edge drives `rep_out_valid` = 1 after that edge, together with the line's bin and `rep_cold` = NOT warm. The line index is `rep_addr[7 +: IDX_W]`, so address bits above the table are ignored.
- R3: A reply sets the addressed line's warm flag, so the next reply to that line reports `rep_cold` = 0 and the same bin.
- R4: An accepted command with start index S = `cmd_addr >> 7` and length L > 0 writes `cmd_bin` into lines S through S+L-1 and clears their warm flags. Lines outside that range keep their tags.
- R5: A range that would pass the last entry stops at the last entry and does not wrap to line 0. A command with L = 0, or with S beyond the last entry, changes no tag and does not raise `busy`.
- R6: `busy` rises after the edge that accepts a non-empty command. One entry is written per clock, so without stalls `busy` stays high for exactly the number of lines written.
- R7: A command presented while `busy` = 1 raises `cmd_retry` in that same cycle and is discarded; it changes no tag.
- R8: When a reply addresses the line the walk would write in that cycle, the reply sees the old tag and the walk stalls for one clock. The walk then writes that line (clearing warm), and `busy` is extended by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Bin-assignment command present |
| cmd_addr | input | ADDR_W | Starting physical address of the range |
| cmd_len | input | LEN_W | Range length in lines |
| cmd_bin | input | BIN_W | Bin number to apply |
| cmd_retry | output | 1 | Command refused because a walk is running |
| busy | output | 1 | Walk in progress |
| rep_valid | input | 1 | Data reply lookup request |
| rep_addr | input | ADDR_W | Physical address of the replied line |
| rep_out_valid | output | 1 | Reply tag result valid |
| rep_bin | output | BIN_W | Bin of the replied line |
| rep_cold | output | 1 | Line was not warm before this reply |

## Verification
A reply result appears one edge after the reply is presented, so the bench drives each reply on a falling edge and samples shortly after the next rising edge. `cmd_retry` is combinational, so it is sampled before the accepting edge. `busy` rises at the accepting edge and falls at the edge that writes the last line. The bench therefore counts rising edges from acceptance, L of them without stalls and L+1 with one collision, and samples `busy` just before and just after the edge where it should fall. Tag effects of a walk are observed only through later replies, once `busy` is low.

// File: rtl/line_tag_pkg.sv
package line_tag_pkg;
  localparam int unsigned TAG_BIN_W = 10;

  typedef struct packed {
    logic                 warm;
    logic [TAG_BIN_W-1:0] bin;
  } line_tag_t;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/line_tag_store.sv
module line_tag_store
  import line_tag_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output line_tag_t        lk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_BIN_W-1:0] wr_bin
);
  line_tag_t tag_q [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
    line_tag_t tag_d;
    logic      hit_lk;
    logic      hit_wr;

    always_comb begin
      hit_lk = lk_en && (lk_idx == IDX_W'(i));
      hit_wr = wr_en && (wr_idx == IDX_W'(i));
      tag_d  = tag_q[i];
      if (hit_wr) begin
        tag_d.bin  = wr_bin;
        tag_d.warm = 1'b0;
      end else if (hit_lk) begin
        tag_d.warm = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
      end else if (hit_wr || hit_lk) begin
        tag_q[i] <= tag_d;
      end
    end
  end

  assign lk_tag = tag_q[lk_idx];
endmodule

// File: rtl/line_tag_walker.sv
module line_tag_walker
  import line_tag_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned LINE_SHIFT = 7,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic [TAG_BIN_W-1:0] cmd_bin,
  output logic                 cmd_retry,
  output logic                 busy,
  input  logic                 lk_en,
  input  logic [IDX_W-1:0]     lk_idx,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [TAG_BIN_W-1:0] wr_bin
);
  localparam logic [ADDR_W:0] LAST_FULL = (ADDR_W+1)'(NUM_LINES - 1);
  localparam logic [ADDR_W:0] ONE_FULL  = (ADDR_W+1)'(1);

  walk_state_e           state_q, state_d;
  logic [IDX_W-1:0]      cur_q, cur_d;
  logic [IDX_W-1:0]      last_q, last_d;
  logic [TAG_BIN_W-1:0]  bin_q, bin_d;

  logic [ADDR_W:0]       start_full;
  logic [ADDR_W:0]       end_full;
  logic [IDX_W-1:0]      end_clip;
  logic                  start_ok;
  logic                  load;
  logic                  stall;
  logic                  step;
  logic                  reg_en;

  always_comb begin
    start_full = {1'b0, (cmd_addr >> LINE_SHIFT)};
    end_full   = start_full + {{(ADDR_W+1-LEN_W){1'b0}}, cmd_len} - ONE_FULL;
    start_ok   = (start_full <= LAST_FULL) && (cmd_len != '0);
    end_clip   = (end_full > LAST_FULL) ? LAST_FULL[IDX_W-1:0] : end_full[IDX_W-1:0];
    load       = (state_q == WALK_IDLE) && cmd_valid && start_ok;
    stall      = (state_q == WALK_RUN) && lk_en && (lk_idx == cur_q);
    step       = (state_q == WALK_RUN) && !stall;
    reg_en     = load || step;
  end

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    bin_d   = bin_q;
    if (load) begin
      state_d = WALK_RUN;
      cur_d   = start_full[IDX_W-1:0];
      last_d  = end_clip;
      bin_d   = cmd_bin;
    end else if (step) begin
      if (cur_q == last_q) begin
        state_d = WALK_IDLE;
      end else begin
        cur_d = cur_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
      bin_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      bin_q   <= bin_d;
    end
  end

  assign busy      = (state_q == WALK_RUN);
  assign cmd_retry = cmd_valid && (state_q == WALK_RUN);
  assign wr_en     = step;
  assign wr_idx    = cur_q;
  assign wr_bin    = bin_q;
endmodule

// File: rtl/line_tag_reply.sv
module line_tag_reply
  import line_tag_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_SHIFT = 7,
  localparam int unsigned IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rep_valid,
  input  logic [ADDR_W-1:0]    rep_addr,
  output logic                 lk_en,
  output logic [IDX_W-1:0]     lk_idx,
  input  line_tag_t            lk_tag,
  output logic                 out_valid,
  output logic [TAG_BIN_W-1:0] out_bin,
  output logic                 out_cold
);
  logic                 valid_d;
  logic [TAG_BIN_W-1:0] bin_d;
  logic                 cold_d;

  assign lk_en  = rep_valid;
  assign lk_idx = rep_addr[LINE_SHIFT +: IDX_W];

  always_comb begin
    valid_d = rep_valid;
    bin_d   = lk_tag.bin;
    cold_d  = !lk_tag.warm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_bin  <= '0;
      out_cold <= 1'b0;
    end else if (rep_valid) begin
      out_bin  <= bin_d;
      out_cold <= cold_d;
    end
  end
endmodule

// File: rtl/line_tag_engine.sv
module line_tag_engine
  import line_tag_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned LINE_SHIFT = 7,
  parameter int unsigned BIN_W      = TAG_BIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BIN_W-1:0]  cmd_bin,
  output logic              cmd_retry,
  output logic              busy,
  input  logic              rep_valid,
  input  logic [ADDR_W-1:0] rep_addr,
  output logic              rep_out_valid,
  output logic [BIN_W-1:0]  rep_bin,
  output logic              rep_cold
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic                 lk_en;
  logic [IDX_W-1:0]     lk_idx;
  line_tag_t            lk_tag;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_idx;
  logic [TAG_BIN_W-1:0] wr_bin;

  line_tag_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_en  (lk_en),
    .lk_idx (lk_idx),
    .lk_tag (lk_tag),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bin (wr_bin)
  );

  line_tag_walker #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .LINE_SHIFT (LINE_SHIFT)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_bin   (cmd_bin),
    .cmd_retry (cmd_retry),
    .busy      (busy),
    .lk_en     (lk_en),
    .lk_idx    (lk_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_bin    (wr_bin)
  );

  line_tag_reply #(
    .NUM_LINES  (NUM_LINES),
    .ADDR_W     (ADDR_W),
    .LINE_SHIFT (LINE_SHIFT)
  ) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .rep_valid (rep_valid),
    .rep_addr  (rep_addr),
    .lk_en     (lk_en),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .out_valid (rep_out_valid),
    .out_bin   (rep_bin),
    .out_cold  (rep_cold)
  );
endmodule

// File: rtl/line_tag_engine_chk.sv
module line_tag_engine_chk #(
  parameter int unsigned NUM_LINES  = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_SHIFT = 7,
  parameter int unsigned BIN_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_retry,
  input logic              busy,
  input logic              rep_valid,
  input logic [ADDR_W-1:0] rep_addr,
  input logic              rep_out_valid,
  input logic [BIN_W-1:0]  rep_bin,
  input logic              rep_cold
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  // R2
  reply_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |=> rep_out_valid);

  // R2
  reply_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_valid |=> !rep_out_valid);

  // R7
  retry_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_retry |-> (busy && cmd_valid));

  // R3
  second_touch_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && $past(rep_valid) && !busy &&
     (rep_addr[LINE_SHIFT +: IDX_W] == $past(rep_addr[LINE_SHIFT +: IDX_W])))
    |=> !rep_cold);

  // R6
  idle_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> !busy);
endmodule

bind line_tag_engine line_tag_engine_chk #(
  .NUM_LINES  (NUM_LINES),
  .ADDR_W     (ADDR_W),
  .LINE_SHIFT (LINE_SHIFT),
  .BIN_W      (BIN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_retry     (cmd_retry),
  .busy          (busy),
  .rep_valid     (rep_valid),
  .rep_addr      (rep_addr),
  .rep_out_valid (rep_out_valid),
  .rep_bin       (rep_bin),
  .rep_cold      (rep_cold)
);

// File: tb/line_tag_engine_tb.sv
module line_tag_engine_tb;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned BIN_W  = 10;

  typedef struct packed {
    logic              is_cmd;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [BIN_W-1:0]  bin;
    logic [BIN_W-1:0]  exp_bin;
    logic              exp_bit;
  } vec_t;

  localparam int NV = 15;
  // reply: exp_bin / exp_bit = expected cold; cmd: exp_bit = expected busy after accept
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd640,       16'd0,  10'd0,     10'd0,     1'b1}, // R1 line 5
    '{1'b0, 32'd640,       16'd0,  10'd0,     10'd0,     1'b0}, // R3 line 5
    '{1'b1, 32'd512,       16'd3,  10'h155,   10'd0,     1'b1}, // R4 lines 4..6
    '{1'b0, 32'd640,       16'd0,  10'd0,     10'h155,   1'b1}, // R4 line 5 relabeled, cold
    '{1'b0, 32'd640,       16'd0,  10'd0,     10'h155,   1'b0}, // R3
    '{1'b0, 32'h0001_0280, 16'd0,  10'd0,     10'h155,   1'b0}, // R2 upper bits ignored
    '{1'b0, 32'd768,       16'd0,  10'd0,     10'h155,   1'b1}, // R4 line 6 end of range
    '{1'b0, 32'd896,       16'd0,  10'd0,     10'd0,     1'b1}, // R4 line 7 untouched
    '{1'b0, 32'd384,       16'd0,  10'd0,     10'd0,     1'b1}, // R4 line 3 untouched
    '{1'b1, 32'd7936,      16'd10, 10'h2AA,   10'd0,     1'b1}, // R5 clip 62..63
    '{1'b0, 32'd8064,      16'd0,  10'd0,     10'h2AA,   1'b1}, // R5 line 63
    '{1'b0, 32'd0,         16'd0,  10'd0,     10'd0,     1'b1}, // R5 no wrap to line 0
    '{1'b1, 32'd1280,      16'd0,  10'd7,     10'd0,     1'b0}, // R5 zero length
    '{1'b1, 32'd8192,      16'd2,  10'd9,     10'd0,     1'b0}, // R5 start past table
    '{1'b0, 32'd1280,      16'd0,  10'd0,     10'd0,     1'b1}  // R5 line 10 untouched
  };

  logic              clk;
  logic              rst_n;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic [BIN_W-1:0]  cmd_bin;
  logic              cmd_retry;
  logic              busy;
  logic              rep_valid;
  logic [ADDR_W-1:0] rep_addr;
  logic              rep_out_valid;
  logic [BIN_W-1:0]  rep_bin;
  logic              rep_cold;

  int errors = 0;
  int checks = 0;

  line_tag_engine u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_addr      (cmd_addr),
    .cmd_len       (cmd_len),
    .cmd_bin       (cmd_bin),
    .cmd_retry     (cmd_retry),
    .busy          (busy),
    .rep_valid     (rep_valid),
    .rep_addr      (rep_addr),
    .rep_out_valid (rep_out_valid),
    .rep_bin       (rep_bin),
    .rep_cold      (rep_cold)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reply(input logic [ADDR_W-1:0] a, input int eb, input int ec, input string req);
    @(negedge clk);
    rep_valid = 1'b1;
    rep_addr  = a;
    @(posedge clk);
    #1;
    rep_valid = 1'b0;
    chk(rep_out_valid == 1'b1, {req, " valid"}, int'(rep_out_valid), 1);
    chk(int'(rep_bin) == eb, {req, " bin"}, int'(rep_bin), eb);
    chk(int'(rep_cold) == ec, {req, " cold"}, int'(rep_cold), ec);
  endtask

  task automatic do_cmd(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                        input logic [BIN_W-1:0] b, input int eb, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    cmd_len   = l;
    cmd_bin   = b;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    chk(int'(busy) == eb, {req, " busy after accept"}, int'(busy), eb);
  endtask

  task automatic wait_idle();
    while (busy) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_addr  = '0;
    cmd_len   = '0;
    cmd_bin   = '0;
    rep_valid = 1'b0;
    rep_addr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(cmd_retry == 1'b0, "R1 retry", int'(cmd_retry), 0);
    chk(rep_out_valid == 1'b0, "R1 out_valid", int'(rep_out_valid), 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_cmd) begin
        do_cmd(VECS[i].addr, VECS[i].len, VECS[i].bin, int'(VECS[i].exp_bit),
               $sformatf("R4/R5/R6 vec%0d", i));
        wait_idle();
      end else begin
        do_reply(VECS[i].addr, int'(VECS[i].exp_bin), int'(VECS[i].exp_bit),
                 $sformatf("R1-R5 vec%0d", i));
      end
    end

    // R6 and R7: eight-line walk, busy window and refused command
    do_cmd(32'd2560, 16'd8, 10'd9, 1, "R6 walk start");
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = 32'd5120;
    cmd_len   = 16'd1;
    cmd_bin   = 10'd3;
    #1;
    chk(cmd_retry == 1'b1, "R7 retry while busy", int'(cmd_retry), 1);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(busy == 1'b1, "R6 busy before last write", int'(busy), 1);
    @(posedge clk);
    #1;
    chk(busy == 1'b0, "R6 busy after last write", int'(busy), 0);
    do_reply(32'd3456, 9, 1, "R4 line 27 in range");
    do_reply(32'd3584, 0, 1, "R4 line 28 outside range");
    do_reply(32'd5120, 0, 1, "R7 refused command no effect");

    // R8: collision of reply and walk on line 30
    do_reply(32'd3840, 0, 1, "R8 warm line 30");
    do_cmd(32'd3840, 16'd2, 10'h11, 1, "R8 walk start");
    @(negedge clk);
    rep_valid = 1'b1;
    rep_addr  = 32'd3840;
    @(posedge clk);
    #1;
    rep_valid = 1'b0;
    chk(int'(rep_bin) == 0, "R8 reply sees old bin", int'(rep_bin), 0);
    chk(rep_cold == 1'b0, "R8 reply sees old warm", int'(rep_cold), 0);
    @(posedge clk);
    #1;
    chk(busy == 1'b1, "R8 busy extended by stall", int'(busy), 1);
    @(posedge clk);
    #1;
    chk(busy == 1'b0, "R8 busy falls after stall", int'(busy), 0);
    do_reply(32'd3840, 17, 1, "R8 line 30 written after stall");
    do_reply(32'd3968, 17, 1, "R8 line 31 written");

    finish_run();
  end
endmodule